// File: doc/BRIEF.md
# Interrupt Status and Rail Alarm Unit

This block gathers eight interrupt causes into one sticky status byte and drives a single active-low, level-sensitive interrupt line towards a host processor. Seven causes arrive from neighbouring blocks as one-cycle pulses. The eighth cause is produced inside the block by two window comparators. Each comparator watches one supply-rail reading, expressed in units of 1/32 V.

A host reaches the block through a small register port. It selects either the status byte or the enable byte, can write the selected byte, and reads it back combinationally. Status bits are cleared by writing ones. The enable byte is an ordinary read/write mask. The interrupt line stays low for as long as any status bit that is enabled is set.

Top module: `irq_rail_hub`

## Requirements
- R1: After reset, status and enable both read 0x00 and `irq_n_o` is high.
- R2: A one-cycle pulse on `evt_i[k]` sets status bit k at the next clock edge. The bit then stays set until it is cleared.
- R3: A write with `reg_sel_i`=0 clears every status bit whose `reg_wdata_i` bit is 1. Status bits whose write bit is 0 are unchanged.
- R4: When a source pulse and a clearing write hit the same bit in the same cycle, the bit stays set.
- R5: A write with `reg_sel_i`=1 replaces the enable byte, and `reg_rdata_o` returns it while `reg_sel_i`=1. Writes to either byte never change the other byte.
- R6: `irq_n_o` is low exactly when (status AND enable) is non-zero. This holds from the cycle after the causing edge.
- R7: Rail A is outside its window when the reading is above 116 or below 95. Readings of 95 and 116 are inside the window.
- R8: Rail B is outside its window when the reading is above 176 or below 144. Readings of 144 and 176 are inside the window.
- R9: Status bit 7 is set only on a clock edge where `sample_vld_i` is high and at least one rail moves from inside its window to outside it, compared with that rail's previous valid sample. The comparison history starts as inside the window after reset. Readings taken while `sample_vld_i` is low are ignored. A rail that stays outside the window does not set the bit again.
- R10: The status bit map is fixed as follows: bit 7 is the rail alarm, and bits 6..0 follow `evt_i[6..0]` at the same index. In that order, the event bits are button change, UART TX empty, UART RX not empty, I2C TX empty, I2C RX not empty, mouse RX not empty, and keyboard RX not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 7 | One-cycle event pulses for status bits 6..0 |
| rail_a_i | input | 8 | Rail A reading, 1/32 V units |
| rail_b_i | input | 8 | Rail B reading, 1/32 V units |
| sample_vld_i | input | 1 | New rail readings are valid this cycle |
| reg_sel_i | input | 1 | 0 selects status, 1 selects enable |
| reg_wr_i | input | 1 | Write strobe for the selected byte |
| reg_wdata_i | input | 8 | Write data (clear mask or new enable) |
| reg_rdata_o | output | 8 | Read data of the selected byte |
| irq_n_o | output | 1 | Active-low level interrupt |

## Verification
Any wrong internal bit shows up on the ports in the cycle after the edge that stored it. A corrupt status or enable bit appears on `reg_rdata_o` as soon as that byte is selected. If the bit is enabled, it also appears on `irq_n_o`. The comparator history is not visible directly, so the bench exposes it through behaviour. It takes rails across each window edge and holds them outside the window over several valid samples. A stale or wrong history then becomes visible as a missing or repeated bit 7 at the next valid sample.

// File: rtl/irq_rail_hub_pkg.sv
package irq_rail_hub_pkg;
    localparam int NUM_SRC   = 8;
    localparam int NUM_EVT   = NUM_SRC - 1;
    localparam int ALARM_BIT = NUM_SRC - 1;
    localparam int NUM_RAIL  = 2;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [NUM_SRC-1:0] status;
        logic [NUM_SRC-1:0] enable;
    } irq_regs_t;

    typedef struct packed {
        logic [NUM_RAIL-1:0] outside;
    } rail_hist_t;
endpackage

// File: rtl/rail_window_cmp.sv
module rail_window_cmp #(
    parameter int              W  = 8,
    parameter logic [W-1:0]    LO = 8'd95,
    parameter logic [W-1:0]    HI = 8'd116
) (
    input  logic [W-1:0] level_i,
    output logic         outside_o
);
    always_comb begin
        outside_o = (level_i > HI) || (level_i < LO);
    end
endmodule

// File: rtl/rail_alarm_unit.sv
module rail_alarm_unit
    import irq_rail_hub_pkg::*;
#(
    parameter int                   W      = 8,
    parameter logic [NUM_RAIL*W-1:0] LO_TBL = {8'd144, 8'd95},
    parameter logic [NUM_RAIL*W-1:0] HI_TBL = {8'd176, 8'd116}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_vld_i,
    input  logic [NUM_RAIL*W-1:0] levels_i,
    output logic                  alarm_set_o
);
    logic [NUM_RAIL-1:0] now_out;
    rail_hist_t          hist_d, hist_q;

    for (genvar r = 0; r < NUM_RAIL; r++) begin : g_rail
        rail_window_cmp #(
            .W  (W),
            .LO (LO_TBL[r*W +: W]),
            .HI (HI_TBL[r*W +: W])
        ) u_cmp (
            .level_i   (levels_i[r*W +: W]),
            .outside_o (now_out[r])
        );
    end

    always_comb begin
        hist_d      = hist_q;
        alarm_set_o = 1'b0;
        if (sample_vld_i) begin
            alarm_set_o    = |(now_out & ~hist_q.outside);
            hist_d.outside = now_out;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_rail_hub_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic               clr_wr_i,
    input  logic               en_wr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] status_o,
    output logic [NUM_SRC-1:0] enable_o
);
    irq_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (clr_wr_i) begin
            regs_d.status = regs_q.status & ~wdata_i;
        end
        regs_d.status = regs_d.status | set_i;
        if (en_wr_i) begin
            regs_d.enable = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign status_o = regs_q.status;
    assign enable_o = regs_q.enable;
endmodule

// File: rtl/irq_rail_hub.sv
module irq_rail_hub
    import irq_rail_hub_pkg::*;
#(
    parameter int               RAIL_W = 8,
    parameter logic [RAIL_W-1:0] A_LO  = 8'd95,
    parameter logic [RAIL_W-1:0] A_HI  = 8'd116,
    parameter logic [RAIL_W-1:0] B_LO  = 8'd144,
    parameter logic [RAIL_W-1:0] B_HI  = 8'd176
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [RAIL_W-1:0]  rail_a_i,
    input  logic [RAIL_W-1:0]  rail_b_i,
    input  logic               sample_vld_i,
    input  logic               reg_sel_i,
    input  logic               reg_wr_i,
    input  logic [NUM_SRC-1:0] reg_wdata_i,
    output logic [NUM_SRC-1:0] reg_rdata_o,
    output logic               irq_n_o
);
    localparam logic [NUM_RAIL*RAIL_W-1:0] LO_TBL = {B_LO, A_LO};
    localparam logic [NUM_RAIL*RAIL_W-1:0] HI_TBL = {B_HI, A_HI};

    logic               alarm_set;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] status_w;
    logic [NUM_SRC-1:0] enable_w;
    logic               clr_wr;
    logic               en_wr;

    rail_alarm_unit #(
        .W      (RAIL_W),
        .LO_TBL (LO_TBL),
        .HI_TBL (HI_TBL)
    ) u_alarm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_vld_i (sample_vld_i),
        .levels_i     ({rail_b_i, rail_a_i}),
        .alarm_set_o  (alarm_set)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[NUM_EVT-1:0] = evt_i;
        set_vec[ALARM_BIT] = alarm_set;
        clr_wr = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_STATUS);
        en_wr  = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_ENABLE);
    end

    irq_status_reg u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .clr_wr_i (clr_wr),
        .en_wr_i  (en_wr),
        .wdata_i  (reg_wdata_i),
        .status_o (status_w),
        .enable_o (enable_w)
    );

    always_comb begin
        reg_rdata_o = (reg_sel_e'(reg_sel_i) == SEL_ENABLE) ? enable_w : status_w;
        irq_n_o     = ~|(status_w & enable_w);
    end
endmodule

// File: rtl/irq_rail_hub_chk.sv
module irq_rail_hub_chk
    import irq_rail_hub_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EVT-1:0] evt_i,
    input logic               sample_vld_i,
    input logic               reg_sel_i,
    input logic               reg_wr_i,
    input logic [NUM_SRC-1:0] reg_wdata_i,
    input logic               irq_n_o,
    input logic [NUM_SRC-1:0] status,
    input logic [NUM_SRC-1:0] enable
);
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && !reg_sel_i) |=> ((status & $past(status)) == $past(status))); // R2
    AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && !reg_sel_i && evt_i == '0 && !sample_vld_i) |=> ((status & $past(reg_wdata_i)) == '0)); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((status[NUM_EVT-1:0] & $past(evt_i)) == $past(evt_i))); // R4
    AST_ENABLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && reg_sel_i) |=> $stable(enable)); // R5
    AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_i & enable[NUM_EVT-1:0]) != '0 && !(reg_wr_i && reg_sel_i)) |=> !irq_n_o); // R6
    AST_ALARM_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_vld_i && !status[ALARM_BIT]) |=> !status[ALARM_BIT]); // R9
endmodule

bind irq_rail_hub irq_rail_hub_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (evt_i),
    .sample_vld_i (sample_vld_i),
    .reg_sel_i    (reg_sel_i),
    .reg_wr_i     (reg_wr_i),
    .reg_wdata_i  (reg_wdata_i),
    .irq_n_o      (irq_n_o),
    .status       (status_w),
    .enable       (enable_w)
);

// File: tb/irq_rail_hub_bench.sv
module irq_rail_hub_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] evt = '0;
    logic [7:0] rail_a = 8'd105;
    logic [7:0] rail_b = 8'd160;
    logic       vld = 1'b0;
    logic       sel = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_n;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    logic [7:0] m_st = '0;
    logic [7:0] m_en = '0;
    bit p_a = 0;
    bit p_b = 0;

    always #10 clk = ~clk;

    irq_rail_hub u_irq_rail_hub (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .rail_a_i(rail_a), .rail_b_i(rail_b),
        .sample_vld_i(vld), .reg_sel_i(sel), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_n_o(irq_n)
    );

    // Behavioural reference, updated on the same edge as the design.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = '0; m_en = '0; p_a = 0; p_b = 0;
        end else begin
            logic [7:0] nst;
            bit na, nb;
            nst = m_st;
            if (wr && !sel) nst = nst & ~wdata;
            nst = nst | {1'b0, evt};
            if (vld) begin
                na = (int'(rail_a) > 116) || (int'(rail_a) < 95);
                nb = (int'(rail_b) > 176) || (int'(rail_b) < 144);
                if ((na && !p_a) || (nb && !p_b)) nst[7] = 1'b1;
                p_a = na; p_b = nb;
            end
            if (wr && sel) m_en = wdata;
            m_st = nst;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 irq level", {7'd0, irq_n}, {7'd0, ~|(m_st & m_en)});
            chk("R5/R2 readback", rdata, sel ? m_en : m_st);
        end
    end

    task automatic cyc();
        @(posedge clk);
        #5;
    endtask

    task automatic rd(input logic s, output logic [7:0] v);
        sel = s;
        #1;
        v = rdata;
    endtask

    task automatic pulse(input logic [6:0] e);
        evt = e; cyc(); evt = '0;
    endtask

    task automatic wreg(input logic s, input logic [7:0] d);
        sel = s; wr = 1'b1; wdata = d; cyc(); wr = 1'b0; wdata = '0;
    endtask

    task automatic sample(input logic [7:0] a, input logic [7:0] b);
        rail_a = a; rail_b = b; vld = 1'b1; cyc(); vld = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        rd(0, v); chk("R1 status", v, 8'h00);
        rd(1, v); chk("R1 enable", v, 8'h00);
        chk("R1 irq", {7'd0, irq_n}, 8'h01);

        // R2 / R10 each event sets its own bit and sticks
        for (int k = 0; k < 7; k++) begin
            pulse(7'(1 << k));
            cyc();
            rd(0, v); chk("R10 bit map", v & 8'(1 << k), 8'(1 << k));
        end
        rd(0, v); chk("R2 sticky", v, 8'h7F);
        chk("R6 masked irq high", {7'd0, irq_n}, 8'h01);

        // R5 enable write and readback, status untouched
        wreg(1, 8'h0F);
        rd(1, v); chk("R5 enable", v, 8'h0F);
        rd(0, v); chk("R5 status kept", v, 8'h7F);
        chk("R6 irq low", {7'd0, irq_n}, 8'h00);

        // R3 write-one-to-clear
        wreg(0, 8'h05);
        rd(0, v); chk("R3 clear", v, 8'h7A);
        rd(1, v); chk("R3 enable kept", v, 8'h0F);
        wreg(0, 8'h00);
        rd(0, v); chk("R3 zero write", v, 8'h7A);

        // R4 set wins over clear
        sel = 0; wr = 1; wdata = 8'h7F; evt = 7'h02; cyc();
        wr = 0; wdata = '0; evt = '0;
        rd(0, v); chk("R4 set wins", v, 8'h02);
        chk("R6 irq from bit1", {7'd0, irq_n}, 8'h00);
        wreg(0, 8'h02);
        chk("R6 irq released", {7'd0, irq_n}, 8'h01);

        // R7 rail A window
        wreg(1, 8'h80);
        sample(8'd95, 8'd160);  rd(0, v); chk("R7 95 inside", v, 8'h00);
        sample(8'd116, 8'd160); rd(0, v); chk("R7 116 inside", v, 8'h00);
        sample(8'd94, 8'd160);  rd(0, v); chk("R7 94 alarm", v, 8'h80);
        chk("R6 alarm irq", {7'd0, irq_n}, 8'h00);
        wreg(0, 8'h80);
        sample(8'd94, 8'd160);  rd(0, v); chk("R9 held out no repeat", v, 8'h00);
        sample(8'd117, 8'd160); rd(0, v); chk("R9 still out", v, 8'h00);
        sample(8'd100, 8'd160); rd(0, v); chk("R7 back inside", v, 8'h00);
        sample(8'd117, 8'd160); rd(0, v); chk("R7 117 alarm", v, 8'h80);
        wreg(0, 8'h80);
        sample(8'd105, 8'd160);

        // R8 rail B window
        sample(8'd105, 8'd144); rd(0, v); chk("R8 144 inside", v, 8'h00);
        sample(8'd105, 8'd176); rd(0, v); chk("R8 176 inside", v, 8'h00);
        sample(8'd105, 8'd177); rd(0, v); chk("R8 177 alarm", v, 8'h80);
        wreg(0, 8'h80);
        sample(8'd105, 8'd160);
        sample(8'd105, 8'd143); rd(0, v); chk("R8 143 alarm", v, 8'h80);
        wreg(0, 8'h80);
        sample(8'd105, 8'd160);

        // R9 readings ignored without the valid strobe
        rail_a = 8'd20; rail_b = 8'd250;
        repeat (3) cyc();
        rd(0, v); chk("R9 no valid", v, 8'h00);
        chk("R9 irq high", {7'd0, irq_n}, 8'h01);
        sample(8'd20, 8'd160); rd(0, v); chk("R9 valid edge", v, 8'h80);

        // R5 full enable mask, mixed traffic
        wreg(1, 8'hFF);
        pulse(7'h55);
        cyc();
        rd(0, v); chk("R2 mixed", v, 8'hD5);
        rd(1, v); chk("R5 full", v, 8'hFF);
        wreg(0, 8'hFF);
        rd(0, v); chk("R3 all clear", v, 8'h00);
        repeat (2) cyc();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule